// File: doc/BRIEF.md
# Fractional-Ratio Decimal Pulse Divider

This block divides an irregular stream of input pulses by a ratio set to one decimal place. The input pulse line is asynchronous to the fast system clock. It is brought into the clock domain through a flop chain, and each rising edge it shows starts a burst of exactly ten one-clock ticks. A two-digit decimal (BCD) down counter consumes those ticks. Each time it has counted down the programmed value it emits one clock-wide output pulse and reloads. Because every input pulse is worth ten ticks, the effective ratio is the programmed value divided by ten: a setting of 37 gives one output per 3.7 input pulses.

The block is meant for pulse trains whose spacing varies widely from pulse to pulse. It only needs each pair of input edges to be at least ten clocks apart. The ratio is read as two BCD digits. A digit above nine counts as nine, and a setting of zero parks the divider with no output.

Top module: `frac_pulse_div`

## Requirements
- R1: `pulse_in` passes through two clock flops before its rising edge is detected. With ratio 01 and `pulse_in` raised before clock edge 1, `div_out` is first high just after edge 4.
- R2: Each detected rising edge of `pulse_in` yields exactly ten ticks, however long the input stays high. With ratio 01, holding the input high for many cycles gives exactly ten output pulses, high just after edges 4 through 13.
- R3: After reset and between bursts no ticks are produced, and `div_out` is 0 directly after reset.
- R4: `ratio_bcd[7:4]` holds the tens digit and `ratio_bcd[3:0]` holds the units digit, giving N = 10*tens + units. From reset, after P input pulses the number of `div_out` pulses equals floor(10*P/N).
- R5: `div_out` is high for one clock per N ticks, and the counter reloads on that same cycle with no lost tick. With ratio 01, every tick gives an output, so a burst gives ten back-to-back high cycles.
- R6: A BCD digit above 9 counts as 9. For example, `ratio_bcd` = 8'h3C divides as N = 39.
- R7: A ratio of 00 produces no output pulses whatever the input does.
- R8: If a new input edge is acted on F clocks after the previous one, with F below ten, the burst restarts from zero and that pair yields F + 10 ticks in total.
- R9: Uneven input spacing, with every edge-to-edge interval at least ten clocks, still gives exactly ten ticks per pulse, so R4 holds for random spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous input pulse line |
| ratio_bcd | input | 8 | Division setting in BCD, tens in [7:4], units in [3:0] |
| div_out | output | 1 | One-clock output pulse per N ticks |

## Verification
An input rising edge that is captured at clock edge k becomes a detected edge after edge k+1. The burst counter clears at edge k+2, and ticks are present for the next ten clock periods. `div_out` is registered, so it follows the qualifying tick by one edge: the first output appears after edge k+3 and the last of a ratio-01 burst after edge k+12. The latency scenario drives inputs at the falling edge and samples `div_out` at every falling edge, so each sample lands half a period after the edge that should have updated it. The count scenarios allow a tail of at least twenty idle clocks after the last input pulse, well past the thirteen-edge pipeline, before the output count is compared with floor(10*P/N).

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int unsigned DIGIT_W  = 4;
    localparam int unsigned DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } bcd2_t;

    function automatic digit_t clamp_digit(input digit_t d);
        return (d > digit_t'(DIGIT_MAX)) ? digit_t'(DIGIT_MAX) : d;
    endfunction

    function automatic bcd2_t clamp_bcd2(input bcd2_t v);
        bcd2_t r;
        r.tens  = clamp_digit(v.tens);
        r.units = clamp_digit(v.units);
        return r;
    endfunction

endpackage

// File: rtl/fd_sync.sv
module fd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its prior value
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fd_burst.sv
module fd_burst #(
    parameter int unsigned BURST_LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(BURST_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                            cnt_q <= CNT_W'(BURST_LEN);
        else if (start)                     cnt_q <= '0;
        else if (cnt_q < CNT_W'(BURST_LEN)) cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q < CNT_W'(BURST_LEN));
endmodule

// File: rtl/fd_bcd_down.sv
module fd_bcd_down
    import frac_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  bcd2_t setting,
    output logic  fire
);
    bcd2_t load_v;
    bcd2_t cnt_q;
    logic  idle_ratio;
    logic  at_end;

    assign load_v     = clamp_bcd2(setting);
    assign idle_ratio = (load_v == '0);
    assign at_end     = (cnt_q.tens == '0) && (cnt_q.units <= digit_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= load_v;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (tick && !idle_ratio) begin
                if (at_end) begin
                    cnt_q <= load_v;
                    fire  <= 1'b1;
                end else if (cnt_q.units == '0) begin
                    cnt_q.units <= digit_t'(DIGIT_MAX);
                    cnt_q.tens  <= cnt_q.tens - 1'b1;
                end else begin
                    cnt_q.units <= cnt_q.units - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frac_pulse_div.sv
module frac_pulse_div
    import frac_div_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BURST_LEN   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse_in,
    input  logic [7:0] ratio_bcd,
    output logic       div_out
);
    logic start_edge;
    logic burst_tick;

    fd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pulse_in), .rise(start_edge)
    );

    fd_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst(rst), .start(start_edge), .tick(burst_tick)
    );

    fd_bcd_down u_div (
        .clk(clk), .rst(rst), .tick(burst_tick),
        .setting(bcd2_t'(ratio_bcd)), .fire(div_out)
    );
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int unsigned BURST_LEN = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       start_edge,
    input logic       burst_tick,
    input logic [7:0] ratio_bcd,
    input logic       div_out
);
    localparam int unsigned RUN_W = $clog2(BURST_LEN + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                            run_q <= RUN_W'(BURST_LEN);
        else if (start_edge)                run_q <= '0;
        else if (burst_tick && run_q < RUN_W'(BURST_LEN)) run_q <= run_q + 1'b1;
    end

    // R2: no tick once ten have been issued since the last edge
    a_r2_burst_len: assert property (@(posedge clk) disable iff (rst)
        (!start_edge && run_q == RUN_W'(BURST_LEN)) |-> !burst_tick);

    // R3: idle after reset until an edge arrives
    a_r3_reset_idle: assert property (@(posedge clk)
        $past(rst) && !rst |-> !div_out && !burst_tick);

    // R5: every output pulse follows a tick
    a_r5_out_after_tick: assert property (@(posedge clk) disable iff (rst)
        div_out |-> $past(burst_tick));

    // R7: zero ratio gives no output
    a_r7_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (ratio_bcd == 8'h00) |=> !div_out);

    // R1: a tick needs a detected edge when the counter was idle
    a_r1_start_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_tick) |-> $past(start_edge));
endmodule

bind frac_pulse_div fd_checker #(.BURST_LEN(BURST_LEN)) u_chk (
    .clk(clk), .rst(rst), .start_edge(start_edge), .burst_tick(burst_tick),
    .ratio_bcd(ratio_bcd), .div_out(div_out)
);

// File: tb/tb_frac_pulse_div.sv
`timescale 1ns/1ps
module tb_frac_pulse_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic [7:0] ratio_bcd = 8'h01;
    logic       div_out;

    int total = 0;
    int bad = 0;
    int out_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    frac_pulse_div dut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .ratio_bcd(ratio_bcd), .div_out(div_out)
    );

    always @(negedge clk) if (!rst && div_out) out_cnt++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] r);
        @(negedge clk);
        ratio_bcd = r;
        pulse_in  = 1'b0;
        rst       = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        out_cnt = 0;
    endtask

    task automatic send_pulse(input int hi, input int lo);
        pulse_in = 1'b1;
        repeat (hi) @(negedge clk);
        pulse_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(8'h01);
        check("R3 reset div_out", int'(div_out), 0);
        repeat (30) @(negedge clk);
        check("R3 idle no output", out_cnt, 0);
    endtask

    task automatic t_latency;
        int miss = 0;
        do_reset(8'h01);
        pulse_in = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (int'(div_out) != ((i >= 4 && i <= 13) ? 1 : 0)) miss++;
            if (i == 3) check("R1 no output before edge 4", int'(div_out), 0);
            if (i == 4) check("R1 first output after edge 4", int'(div_out), 1);
        end
        pulse_in = 1'b0;
        check("R5 back-to-back pattern mismatches", miss, 0);
        check("R2 long high one burst", out_cnt, 10);
    endtask

    task automatic t_ratio(input logic [7:0] r, input int n, input int p, input string req);
        do_reset(r);
        for (int i = 0; i < p; i++) send_pulse(1 + (i % 3), 12 + (i % 5) * 7);
        repeat (25) @(negedge clk);
        check(req, out_cnt, (n == 0) ? 0 : (10 * p) / n);
    endtask

    task automatic t_restart;
        do_reset(8'h01);
        send_pulse(2, 3);
        send_pulse(2, 30);
        check("R8 restart gives F+10 ticks", out_cnt, 15);
    endtask

    task automatic t_random;
        int p = 25;
        do_reset(8'h37);
        for (int i = 0; i < p; i++) send_pulse($urandom_range(3, 1), $urandom_range(60, 10));
        repeat (25) @(negedge clk);
        check("R9 random spacing ratio 3.7", out_cnt, (10 * p) / 37);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_ratio(8'h10, 10, 10, "R4 ratio 1.0");
        t_ratio(8'h25, 25, 12, "R4 ratio 2.5");
        t_ratio(8'h99, 99, 20, "R4 ratio 9.9 tens borrow");
        t_ratio(8'h03, 3, 7, "R5 ratio 0.3");
        t_ratio(8'h3C, 39, 12, "R6 units digit clamp");
        t_ratio(8'hF2, 92, 19, "R6 tens digit clamp");
        t_ratio(8'h00, 0, 8, "R7 ratio zero");
        t_restart();
        t_random();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule